// File: doc/BRIEF.md
# Special-Instruction Memory Port Arbiter

This block shares one data-memory port between two requesters: the core's load/store unit and a multi-cycle special-instruction (SI) engine. A load/store asks for the port with a single request and is granted at once when the port is free. An SI is launched with a start pulse carrying a base address, a stride, an element count and a direction. The block then walks the addresses itself, one memory access per element, and returns each read word through its own valid strobe.

While an SI runs, the core pipeline is frozen through a stall output. Because the core cannot issue anything during that time, the only possible conflict is an SI launched while the load/store just before it is still waiting on memory, or launched in the same cycle as that load/store. In both cases the load/store keeps or takes the port first, and the SI stream starts only when it has finished. The memory side is a request held until the memory answers with a ready strobe one or more cycles later.

The controller has five states. IDLE: port free. LSU: a load/store owns the port. LSU_SIQ: a load/store owns the port and an SI is queued behind it. SI_MEM: the SI stream owns the port. SI_END: a one-cycle completion state. The transitions are:
- IDLE to LSU on a load/store request.
- IDLE to LSU_SIQ on a load/store request together with a start.
- IDLE to SI_MEM on a start with a nonzero count.
- IDLE to SI_END on a start with a zero count.
- LSU to LSU_SIQ on a start before memory answers.
- LSU to IDLE, SI_MEM or SI_END when memory answers.
- LSU_SIQ to SI_MEM or SI_END when memory answers.
- SI_MEM to SI_END when the last element completes.
- SI_END to IDLE.

Top module: `si_mem_arbiter`

## Requirements
- R1: During and straight after reset, no grant, no memory request, no stall and no done strobe is asserted.
- R2: In IDLE a load/store request is granted (`lsu_gnt`=1) in the same cycle. From the next cycle `mem_req`=1 carries its address, direction and data. `lsu_rvalid` returns `mem_rdata` in the cycle `mem_ready`=1.
- R3: Once `mem_req` is high it stays high with unchanged `mem_addr` and `mem_we` until a cycle with `mem_ready`=1; the port owner never changes mid-access.
- R4: An SI with count N>0 performs exactly N accesses, in order, at base + k*stride for k = 0..N-1, with the sum taken modulo 2^AW. Each read returns through `si_rvalid`/`si_rdata`. Each write carries `si_wdata`.
- R5: `core_stall` is 1 from the cycle after an accepted start up to and including the cycle of `si_done`, and 0 in the cycle after it.
- R6: `si_done` is a one-cycle pulse in the cycle after the last element's `mem_ready`, or in the cycle after the start when the count is 0.
- R7: A start issued while a load/store is pending, or together with a load/store request in IDLE, waits. The load/store access completes first, and the first SI access is presented in the cycle after the load/store's `mem_ready`.
- R8: `lsu_gnt` and `si_gnt` are never both 1. A load/store request raised while `core_stall`=1 receives no grant and causes no memory access.
- R9: An SI with count 0 makes no memory access and receives no `si_gnt`.
- R10: `si_gnt` pulses in the cycle at whose end the SI stream takes the port. That cycle is the start cycle when the port is idle, or the `mem_ready` cycle of a load/store the SI waited behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lsu_req | input | 1 | Load/store access request |
| lsu_we | input | 1 | Load/store direction, 1 = write |
| lsu_addr | input | AW | Load/store address |
| lsu_wdata | input | DW | Load/store write data |
| lsu_gnt | output | 1 | Load/store request accepted this cycle |
| lsu_rvalid | output | 1 | Load/store access completed this cycle |
| lsu_rdata | output | DW | Load/store read data |
| si_start | input | 1 | SI launch pulse |
| si_we | input | 1 | SI stream direction, 1 = write |
| si_base | input | AW | SI first address |
| si_stride | input | AW | SI address increment per element |
| si_count | input | CW | SI element count |
| si_wdata | input | DW | SI write data for the current element |
| si_gnt | output | 1 | SI stream takes the port at this edge |
| si_rvalid | output | 1 | SI element completed this cycle |
| si_rdata | output | DW | SI element read data |
| si_done | output | 1 | SI finished, stall released next cycle |
| core_stall | output | 1 | Freeze the core pipeline |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access direction |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_ready | input | 1 | Memory completes the current access |
| mem_rdata | input | DW | Memory read data |

## Verification
Grants are combinational and are due in the request cycle, while `mem_req` and the stall appear one cycle after the accepting edge. Completion strobes coincide with `mem_ready`. `si_done` follows N·L+1 cycles after an idle start, (L−1)+N·L+1 after a start behind a pending load/store, and L+N·L+1 after a same-cycle collision, with L the memory latency. The bench drives inputs just after the falling edge and samples outputs a little later in the same low phase. It counts cycles from the start pulse and compares that count with these formulas. A scoreboard queue holds every expected access in the order the rules dictate, so a wrong arbitration order or a stray access shows up as a mismatch.

// File: rtl/sia_pkg.sv
package sia_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LSU,
        ST_LSU_SIQ,
        ST_SI_MEM,
        ST_SI_END
    } arb_state_e;

endpackage

// File: rtl/sia_addr_gen.sv
module sia_addr_gen #(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          step_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] stride_i,
    input  logic [CW-1:0] count_i,
    input  logic          we_i,
    output logic [AW-1:0] addr_o,
    output logic          we_o,
    output logic          last_o,
    output logic          empty_o
);

    localparam logic [CW-1:0] ONE = CW'(1);

    logic [AW-1:0] addr_q;
    logic [AW-1:0] stride_q;
    logic [CW-1:0] remain_q;
    logic          we_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            stride_q <= '0;
            remain_q <= '0;
            we_q     <= 1'b0;
        end else if (load_i) begin
            addr_q   <= base_i;
            stride_q <= stride_i;
            remain_q <= count_i;
            we_q     <= we_i;
        end else if (step_i) begin
            addr_q   <= addr_q + stride_q;
            remain_q <= remain_q - ONE;
        end
    end

    assign addr_o  = addr_q;
    assign we_o    = we_q;
    assign last_o  = (remain_q == ONE);
    assign empty_o = (remain_q == '0);

endmodule

// File: rtl/sia_fsm.sv
module sia_fsm
    import sia_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lsu_req_i,
    input  logic si_start_i,
    input  logic si_zero_i,
    input  logic gen_last_i,
    input  logic gen_empty_i,
    input  logic mem_ready_i,
    output logic lsu_gnt_o,
    output logic lsu_cap_o,
    output logic lsu_rvalid_o,
    output logic si_gnt_o,
    output logic si_load_o,
    output logic si_step_o,
    output logic si_rvalid_o,
    output logic si_done_o,
    output logic sel_si_o,
    output logic mem_req_o,
    output logic core_stall_o
);

    arb_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d      = state_q;
        lsu_gnt_o    = 1'b0;
        lsu_cap_o    = 1'b0;
        lsu_rvalid_o = 1'b0;
        si_gnt_o     = 1'b0;
        si_load_o    = 1'b0;
        si_step_o    = 1'b0;
        si_rvalid_o  = 1'b0;
        si_done_o    = 1'b0;
        sel_si_o     = 1'b0;
        mem_req_o    = 1'b0;
        core_stall_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (lsu_req_i) begin
                    lsu_gnt_o = 1'b1;
                    lsu_cap_o = 1'b1;
                    si_load_o = si_start_i;
                    state_d   = si_start_i ? ST_LSU_SIQ : ST_LSU;
                end else if (si_start_i) begin
                    si_load_o = 1'b1;
                    si_gnt_o  = !si_zero_i;
                    state_d   = si_zero_i ? ST_SI_END : ST_SI_MEM;
                end
            end
            ST_LSU: begin
                mem_req_o = 1'b1;
                if (mem_ready_i) begin
                    lsu_rvalid_o = 1'b1;
                    if (si_start_i) begin
                        si_load_o = 1'b1;
                        si_gnt_o  = !si_zero_i;
                        state_d   = si_zero_i ? ST_SI_END : ST_SI_MEM;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end else if (si_start_i) begin
                    si_load_o = 1'b1;
                    state_d   = ST_LSU_SIQ;
                end
            end
            ST_LSU_SIQ: begin
                mem_req_o    = 1'b1;
                core_stall_o = 1'b1;
                if (mem_ready_i) begin
                    lsu_rvalid_o = 1'b1;
                    si_gnt_o     = !gen_empty_i;
                    state_d      = gen_empty_i ? ST_SI_END : ST_SI_MEM;
                end
            end
            ST_SI_MEM: begin
                mem_req_o    = 1'b1;
                sel_si_o     = 1'b1;
                core_stall_o = 1'b1;
                if (mem_ready_i) begin
                    si_rvalid_o = 1'b1;
                    si_step_o   = 1'b1;
                    if (gen_last_i) state_d = ST_SI_END;
                end
            end
            ST_SI_END: begin
                core_stall_o = 1'b1;
                si_done_o    = 1'b1;
                state_d      = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/si_mem_arbiter.sv
module si_mem_arbiter #(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lsu_req,
    input  logic          lsu_we,
    input  logic [AW-1:0] lsu_addr,
    input  logic [DW-1:0] lsu_wdata,
    output logic          lsu_gnt,
    output logic          lsu_rvalid,
    output logic [DW-1:0] lsu_rdata,
    input  logic          si_start,
    input  logic          si_we,
    input  logic [AW-1:0] si_base,
    input  logic [AW-1:0] si_stride,
    input  logic [CW-1:0] si_count,
    input  logic [DW-1:0] si_wdata,
    output logic          si_gnt,
    output logic          si_rvalid,
    output logic [DW-1:0] si_rdata,
    output logic          si_done,
    output logic          core_stall,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ready,
    input  logic [DW-1:0] mem_rdata
);

    logic          lsu_cap, si_load, si_step, sel_si;
    logic          gen_last, gen_empty, gen_we;
    logic [AW-1:0] gen_addr;
    logic [AW-1:0] lsu_addr_q;
    logic [DW-1:0] lsu_wdata_q;
    logic          lsu_we_q;

    sia_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .lsu_req_i    (lsu_req),
        .si_start_i   (si_start),
        .si_zero_i    (si_count == '0),
        .gen_last_i   (gen_last),
        .gen_empty_i  (gen_empty),
        .mem_ready_i  (mem_ready),
        .lsu_gnt_o    (lsu_gnt),
        .lsu_cap_o    (lsu_cap),
        .lsu_rvalid_o (lsu_rvalid),
        .si_gnt_o     (si_gnt),
        .si_load_o    (si_load),
        .si_step_o    (si_step),
        .si_rvalid_o  (si_rvalid),
        .si_done_o    (si_done),
        .sel_si_o     (sel_si),
        .mem_req_o    (mem_req),
        .core_stall_o (core_stall)
    );

    sia_addr_gen #(.AW(AW), .CW(CW)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (si_load),
        .step_i   (si_step),
        .base_i   (si_base),
        .stride_i (si_stride),
        .count_i  (si_count),
        .we_i     (si_we),
        .addr_o   (gen_addr),
        .we_o     (gen_we),
        .last_o   (gen_last),
        .empty_o  (gen_empty)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lsu_addr_q  <= '0;
            lsu_wdata_q <= '0;
            lsu_we_q    <= 1'b0;
        end else if (lsu_cap) begin
            lsu_addr_q  <= lsu_addr;
            lsu_wdata_q <= lsu_wdata;
            lsu_we_q    <= lsu_we;
        end
    end

    assign mem_addr  = sel_si ? gen_addr : lsu_addr_q;
    assign mem_we    = sel_si ? gen_we   : lsu_we_q;
    assign mem_wdata = sel_si ? si_wdata : lsu_wdata_q;
    assign lsu_rdata = mem_rdata;
    assign si_rdata  = mem_rdata;

endmodule

// File: rtl/sia_checker.sv
module sia_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          lsu_gnt,
    input logic          si_gnt,
    input logic          lsu_rvalid,
    input logic          si_rvalid,
    input logic          si_done,
    input logic          core_stall,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ready
);

    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (!mem_req && !core_stall && !si_done)
                else $error("R1 outputs active in reset");
        end
    end

    p_hold_port_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we))
        else $error("R3 port changed mid-access");

    p_done_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        si_done |=> !core_stall)
        else $error("R5 stall held after done");

    p_si_under_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        si_rvalid |-> core_stall)
        else $error("R5 SI access without stall");

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        si_done |=> !si_done)
        else $error("R6 done longer than a cycle");

    p_excl_gnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(lsu_gnt && si_gnt))
        else $error("R8 double grant");

    p_stall_blocks_lsu_r8: assert property (@(posedge clk) disable iff (!rst_n)
        core_stall |-> !lsu_gnt)
        else $error("R8 grant while stalled");

    p_one_completion_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(lsu_rvalid && si_rvalid))
        else $error("R2 two completions");

endmodule

bind si_mem_arbiter sia_checker #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lsu_gnt    (lsu_gnt),
    .si_gnt     (si_gnt),
    .lsu_rvalid (lsu_rvalid),
    .si_rvalid  (si_rvalid),
    .si_done    (si_done),
    .core_stall (core_stall),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_ready  (mem_ready)
);

// File: tb/si_mem_arbiter_bench.sv
`timescale 1ns/1ps
module si_mem_arbiter_bench;

    localparam int AW = 16;
    localparam int DW = 32;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lsu_req = 1'b0, lsu_we = 1'b0;
    logic [AW-1:0] lsu_addr = '0;
    logic [DW-1:0] lsu_wdata = '0;
    logic          lsu_gnt, lsu_rvalid;
    logic [DW-1:0] lsu_rdata;
    logic          si_start = 1'b0, si_we = 1'b0;
    logic [AW-1:0] si_base = '0, si_stride = '0;
    logic [CW-1:0] si_count = '0;
    logic [DW-1:0] si_wdata = '0;
    logic          si_gnt, si_rvalid, si_done, core_stall;
    logic [DW-1:0] si_rdata;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ready = 1'b0;
    logic [DW-1:0] mem_rdata = '0;

    si_mem_arbiter #(.AW(AW), .DW(DW), .CW(CW)) u_si_mem_arbiter (.*);

    always #10 clk = ~clk;

    int n_checks = 0;
    int n_errs   = 0;
    int lat      = 1;
    int mcnt     = 0;
    logic [DW-1:0] mem    [256];
    logic [DW-1:0] shadow [256];

    typedef struct {
        bit            is_si;
        bit            we;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        string         tag;
    } acc_t;
    acc_t exp_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory model: writes at the edge, ready/data decided in the low phase
    always @(posedge clk) begin
        if (mem_req && mem_ready && mem_we) mem[mem_addr[7:0]] = mem_wdata;
    end

    always @(negedge clk) begin
        if (mem_ready) mcnt = 0;
        if (mem_req) begin
            mcnt++;
            mem_ready = (mcnt >= lat);
        end else begin
            mcnt = 0;
            mem_ready = 1'b0;
        end
        mem_rdata = mem[mem_addr[7:0]];
    end

    // scoreboard monitor
    always begin
        @(negedge clk);
        #2;
        if (rst_n && mem_req && mem_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8", "unexpected memory access", 32'(mem_addr), 32'hFFFF_FFFF);
            end else begin
                acc_t e;
                e = exp_q.pop_front();
                chk(mem_addr === e.addr, e.tag, "access address/order", 32'(mem_addr), 32'(e.addr));
                chk(mem_we === e.we, e.tag, "access direction", 32'(mem_we), 32'(e.we));
                if (e.is_si) chk(si_rvalid === 1'b1 && lsu_rvalid === 1'b0, e.tag, "si_rvalid owner",
                                 {30'd0, si_rvalid, lsu_rvalid}, 32'd2);
                else         chk(lsu_rvalid === 1'b1 && si_rvalid === 1'b0, e.tag, "lsu_rvalid owner",
                                 {30'd0, si_rvalid, lsu_rvalid}, 32'd1);
                if (e.we) chk(mem_wdata === e.data, e.tag, "write data", mem_wdata, e.data);
                else if (e.is_si) chk(si_rdata === e.data, e.tag, "si read data", si_rdata, e.data);
                else chk(lsu_rdata === e.data, e.tag, "lsu read data", lsu_rdata, e.data);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic push_acc(bit is_si, bit we, logic [AW-1:0] a, logic [DW-1:0] d, string tag);
        acc_t e;
        e.is_si = is_si; e.we = we; e.addr = a; e.tag = tag;
        if (we) begin
            shadow[a[7:0]] = d;
            e.data = d;
        end else begin
            e.data = shadow[a[7:0]];
        end
        exp_q.push_back(e);
    endtask

    task automatic lsu_issue(bit we, logic [AW-1:0] a, logic [DW-1:0] d, string tag);
        lsu_we = we; lsu_addr = a; lsu_wdata = d; lsu_req = 1'b1;
        #1;
        chk(lsu_gnt === 1'b1, "R2", "lsu_gnt in request cycle", 32'(lsu_gnt), 32'd1);
        push_acc(1'b0, we, a, d, tag);
        tick();
        lsu_req = 1'b0;
        chk(mem_req === 1'b1 && mem_addr === a, "R2", "port driven after grant",
            32'(mem_addr), 32'(a));
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000; i++) begin
            if (exp_q.size() == 0 && !mem_req && !core_stall) break;
            tick();
        end
    endtask

    task automatic si_run(logic [AW-1:0] base, logic [AW-1:0] stride, logic [CW-1:0] cnt,
                          bit we, logic [DW-1:0] wd, bit exp_gnt, int exp_cycles,
                          bit hold_lsu, string tag);
        int c;
        int stall_bad;
        int gnt_bad;
        si_base = base; si_stride = stride; si_count = cnt; si_we = we; si_wdata = wd;
        si_start = 1'b1;
        #1;
        chk(si_gnt === exp_gnt, "R10", "si_gnt in start cycle", 32'(si_gnt), 32'(exp_gnt));
        for (int k = 0; k < int'(cnt); k++)
            push_acc(1'b1, we, base + AW'(k) * stride, wd, tag);
        tick();
        si_start = 1'b0;
        lsu_req  = hold_lsu;
        if (hold_lsu) begin
            lsu_addr = 16'h0033; lsu_we = 1'b1; lsu_wdata = 32'hDEAD_BEEF;
        end
        c = 1; stall_bad = 0; gnt_bad = 0;
        while (c < 2000) begin
            #1;
            if (core_stall !== 1'b1) stall_bad++;
            if (hold_lsu && lsu_gnt !== 1'b0) gnt_bad++;
            if (si_done === 1'b1) break;
            tick();
            c++;
        end
        lsu_req = 1'b0;
        chk(c == exp_cycles, "R6", "cycles from start to si_done", 32'(c), 32'(exp_cycles));
        chk(stall_bad == 0, "R5", "stall gaps during SI", 32'(stall_bad), 32'd0);
        if (hold_lsu) chk(gnt_bad == 0, "R8", "lsu grants while stalled", 32'(gnt_bad), 32'd0);
        tick();
        chk(core_stall === 1'b0 && si_done === 1'b0, "R5", "stall released after done",
            {30'd0, core_stall, si_done}, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]    = 32'hC0DE_0000 + 32'(i) * 17;
            shadow[i] = 32'hC0DE_0000 + 32'(i) * 17;
        end
        repeat (3) tick();
        chk(mem_req === 1'b0 && core_stall === 1'b0 && lsu_gnt === 1'b0 &&
            si_gnt === 1'b0 && si_done === 1'b0, "R1", "quiet in reset",
            {27'd0, mem_req, core_stall, lsu_gnt, si_gnt, si_done}, 32'd0);
        rst_n = 1'b1;
        tick();
        chk(mem_req === 1'b0 && core_stall === 1'b0, "R1", "idle after reset",
            {30'd0, mem_req, core_stall}, 32'd0);

        // R2: plain load/store traffic, latency 1
        lat = 1;
        lsu_issue(1'b1, 16'h0010, 32'h1234_5678, "R2"); wait_idle();
        lsu_issue(1'b0, 16'h0010, '0, "R2");             wait_idle();
        lsu_issue(1'b0, 16'h0020, '0, "R2");             wait_idle();

        // R3: slow memory, port must hold
        lat = 3;
        lsu_issue(1'b0, 16'h0021, '0, "R3");
        tick();
        chk(mem_req === 1'b1 && mem_addr === 16'h0021, "R3", "request held while waiting",
            32'(mem_addr), 32'h0021);
        wait_idle();

        // R4: SI read stream, latency 1
        lat = 1;
        si_run(16'h0040, 16'h0004, 8'd5, 1'b0, '0, 1'b1, 5 * 1 + 1, 1'b0, "R4");
        wait_idle();

        // R4: SI write stream, latency 2, then read back
        lat = 2;
        si_run(16'h0080, 16'h0003, 8'd4, 1'b1, 32'hA5A5_0F0F, 1'b1, 4 * 2 + 1, 1'b0, "R4");
        wait_idle();
        lsu_issue(1'b0, 16'h0083, '0, "R4"); wait_idle();

        // R4: address wraps modulo 2^AW
        lat = 1;
        si_run(16'hFFFE, 16'h0001, 8'd4, 1'b0, '0, 1'b1, 4 * 1 + 1, 1'b0, "R4");
        wait_idle();

        // R9: zero-count SI
        si_run(16'h0050, 16'h0001, 8'd0, 1'b0, '0, 1'b0, 1, 1'b0, "R9");
        wait_idle();

        // R7: SI launched behind a pending load/store
        lat = 3;
        lsu_issue(1'b0, 16'h0022, '0, "R7");
        si_run(16'h0060, 16'h0002, 8'd3, 1'b0, '0, 1'b0, (3 - 1) + 3 * 3 + 1, 1'b0, "R7");
        wait_idle();

        // R7: load/store and SI start in the same idle cycle
        lat = 2;
        lsu_we = 1'b1; lsu_addr = 16'h0024; lsu_wdata = 32'h0BAD_F00D; lsu_req = 1'b1;
        push_acc(1'b0, 1'b1, 16'h0024, 32'h0BAD_F00D, "R7");
        #1;
        chk(lsu_gnt === 1'b1, "R7", "load/store wins same-cycle tie", 32'(lsu_gnt), 32'd1);
        si_run(16'h0024, 16'h0001, 8'd2, 1'b0, '0, 1'b0, 2 + 2 * 2 + 1, 1'b0, "R7");
        wait_idle();

        // R8: load/store request raised during an SI is ignored
        lat = 2;
        si_run(16'h0070, 16'h0001, 8'd3, 1'b0, '0, 1'b1, 3 * 2 + 1, 1'b1, "R8");
        wait_idle();
        lsu_issue(1'b0, 16'h0033, '0, "R8"); wait_idle();

        chk(exp_q.size() == 0, "R4", "all expected accesses performed", 32'(exp_q.size()), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

endmodule